// File: doc/BRIEF.md
# Complex Comb Decimator with Droop Equalizer

This block lowers the sample rate of one complex baseband channel by an integer factor `ND`. Each of the real and imaginary lanes runs a cascade of `NS = K + 1` integrators at the input rate, where `K` is the order of the modulator that feeds it. It then runs the same number of first-difference combs once for every `ND` accepted samples. The comb result is scaled back to unity DC gain by a fixed-point multiply. A symmetric three-tap equalizer with taps (a, b, a) follows and flattens the sinc-shaped passband droop.

Both lanes share one decimation phase counter, so the two halves of a complex sample are always decimated together. The two equalizer coefficients come from a register bank outside the block and are seen here as plain inputs. They take effect on the next output sample.

Top module: `cic_droop_decim`

## Requirements
- R1: While `rst_n` is low, and after its release until the first output, `out_vld` is 0 and `out_re` and `out_im` are 0.
- R2: `out_vld` goes high for exactly one cycle for every `ND` accepted input samples. It is seen in the second cycle after the clock edge that accepted the `ND`-th sample. Two consecutive cycles never both carry `out_vld`.
- R3: A cycle with `in_vld` low changes no filter state and moves no phase. The next decimated output is the same as if the idle cycle had not been there.
- R4: Before scaling, each decimated lane value is the convolution of that lane's accepted samples with the `NS`-fold self-convolution of a length-`ND` run of ones. This gives `NS*(ND-1)+1` taps, aligned so that the newest tap is the sample accepted at the decimating edge. Samples before reset count as zero.
- R5: The comb value `c` is normalized to `y = (c*M + 2^(F-1)) >>> F`, with `F` equal to the integrator width and `M = round(2^F / ND^NS)`. With the defaults (`ND`=5, `NS`=4, 24-bit integrators) `M` is 26844. A constant input therefore settles to the same constant.
- R6: Each output is `(a*y[m] + b*y[m-1] + a*y[m-2] + 8192) >>> 14`, where `y[m]` is the newest normalized value. `a` and `b` are signed 16-bit numbers with 14 fractional bits (16384 means 1.0).
- R7: An equalizer result outside the signed `DW`-bit range is clamped to the largest or smallest value of that range.
- R8: The two lanes are independent and identical. A lane whose input is always zero yields zero outputs, whatever the other lane carries.
- R9: A new coefficient pair applied between outputs is used for the next output.
- R10: The phase counter counts only accepted samples and wraps from `ND-1` to 0, so decimation instants are every `ND`-th accepted sample, independent of gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input sample strobe |
| in_re | input | DW | Real input sample, signed |
| in_im | input | DW | Imaginary input sample, signed |
| coef_a | input | CW | Outer equalizer tap, signed Q2.14 |
| coef_b | input | CW | Centre equalizer tap, signed Q2.14 |
| out_vld | output | 1 | Output sample strobe, one per ND inputs |
| out_re | output | DW | Real output sample, signed |
| out_im | output | DW | Imaginary output sample, signed |

## Verification
Some properties hold on every cycle, and the assertions check those. The phase counter stays below `ND` and stands still through idle cycles. Integrator and delay-line state holds when nothing is accepted. Output strobes never come back to back, and each follows an accepted sample two edges earlier. The output registers change only on a strobe.

Other behaviour can only be shown by the bench scenarios against a software model. That covers the filter's numerical response to steps, impulses, ramps and gapped streams. It also covers the rounding in the normalization, clamping at full scale, the independence of the two lanes, and the moment when a changed coefficient pair takes effect.

// File: rtl/cicdd_pkg.sv
`timescale 1ns/1ps
package cicdd_pkg;
  // Fixed-point multiplier that undoes the comb gain ND^NS at shift SH.
  function automatic longint norm_mult(input int nd, input int ns, input int sh);
    longint den;
    den = 1;
    for (int i = 0; i < ns; i++) den = den * nd;
    return ((longint'(1) << sh) + den / 2) / den;
  endfunction
endpackage

// File: rtl/cicdd_integ.sv
`timescale 1ns/1ps
module cicdd_integ #(
  parameter int DW = 12,
  parameter int RW = 24,
  parameter int NS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] din,
  output logic signed [RW-1:0] sum_nxt
);
  logic signed [RW-1:0] acc_q [NS];
  logic signed [RW-1:0] acc_d [NS];

  // Ripple chain: every stage sees the freshly updated stage before it.
  always_comb begin
    acc_d[0] = acc_q[0] + RW'(din);
    for (int i = 1; i < NS; i++) acc_d[i] = acc_q[i] + acc_d[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) acc_q[i] <= '0;
    end else if (en) begin
      for (int i = 0; i < NS; i++) acc_q[i] <= acc_d[i];
    end
  end

  assign sum_nxt = acc_d[NS-1];

  // R3: idle cycles leave the integrators untouched
  a_r3_integ_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q[NS-1]) && $stable(acc_q[0]));
endmodule

// File: rtl/cicdd_comb.sv
`timescale 1ns/1ps
module cicdd_comb #(
  parameter int RW = 24,
  parameter int NS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [RW-1:0] din,
  output logic signed [RW-1:0] dout
);
  logic signed [RW-1:0] dly_q [NS];
  logic signed [RW-1:0] stg_in [NS];
  logic signed [RW-1:0] diff [NS];

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      stg_in[i] = (i == 0) ? din : diff[(i == 0) ? 0 : i-1];
      diff[i]   = stg_in[i] - dly_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) dly_q[i] <= '0;
    end else if (en) begin
      for (int i = 0; i < NS; i++) dly_q[i] <= stg_in[i];
    end
  end

  assign dout = diff[NS-1];

  // R10: comb delay state only moves at a decimation instant
  a_r10_comb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dly_q[0]));
endmodule

// File: rtl/cicdd_eq.sv
`timescale 1ns/1ps
module cicdd_eq #(
  parameter int     DW   = 12,
  parameter int     RW   = 24,
  parameter int     CW   = 16,
  parameter int     NSH  = 24,
  parameter longint NRM  = 26844,
  parameter int     MW   = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 emit,
  input  logic signed [RW-1:0] cic_in,
  input  logic signed [CW-1:0] ca,
  input  logic signed [CW-1:0] cb,
  output logic signed [DW-1:0] dout
);
  localparam int YW = DW + 1;
  localparam int PW = RW + MW;
  localparam int AW = CW + YW + 2;
  localparam logic signed [MW-1:0] NRM_C = MW'(NRM);
  localparam logic signed [AW-1:0] OMAX  = AW'((longint'(1) << (DW-1)) - 1);
  localparam logic signed [AW-1:0] OMIN  = AW'(-(longint'(1) << (DW-1)));

  logic signed [PW-1:0] prod, prnd;
  logic signed [YW-1:0] y_d, y0_q, y1_q, y2_q;
  logic signed [AW-1:0] acc, arnd, ash;
  logic signed [DW-1:0] o_d, o_q;

  // Normalization back to unity DC gain.
  always_comb begin
    prod = PW'(cic_in) * PW'(NRM_C);
    prnd = prod + (PW'(1) <<< (NSH-1));
    y_d  = YW'(prnd >>> NSH);
  end

  // Symmetric droop equalizer, round then clamp.
  always_comb begin
    acc  = AW'(ca) * AW'(y0_q) + AW'(cb) * AW'(y1_q) + AW'(ca) * AW'(y2_q);
    arnd = acc + (AW'(1) <<< (CW-3));
    ash  = arnd >>> (CW-2);
    if (ash > OMAX)      o_d = DW'(OMAX);
    else if (ash < OMIN) o_d = DW'(OMIN);
    else                 o_d = DW'(ash);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y0_q <= '0; y1_q <= '0; y2_q <= '0;
    end else if (load) begin
      y0_q <= y_d; y1_q <= y0_q; y2_q <= y1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    o_q <= '0;
    else if (emit) o_q <= o_d;
  end

  assign dout = o_q;

  // R6: output register changes only when a result is emitted
  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !emit |=> $stable(o_q));
  // R5: the tap line shifts only on a decimation load
  a_r5_tap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(y0_q) && $stable(y2_q));
endmodule

// File: rtl/cic_droop_decim.sv
`timescale 1ns/1ps
module cic_droop_decim #(
  parameter int DW = 12,
  parameter int K  = 3,
  parameter int ND = 5,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic signed [CW-1:0] coef_a,
  input  logic signed [CW-1:0] coef_b,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);
  import cicdd_pkg::*;
  localparam int     NS   = K + 1;
  localparam int     PHW  = (ND > 1) ? $clog2(ND) : 1;
  localparam int     RW   = DW + NS * PHW;
  localparam longint NRM  = norm_mult(ND, NS, RW);
  localparam int     MW   = $clog2(NRM + 1) + 1;

  logic [PHW-1:0] ph_q, ph_d;
  logic           fire, stb_q, ovld_q;
  logic signed [DW-1:0] lane_in  [2];
  logic signed [DW-1:0] lane_out [2];

  assign fire = in_vld && (ph_q == PHW'(ND-1));

  always_comb begin
    ph_d = ph_q;
    if (in_vld) ph_d = fire ? '0 : ph_q + PHW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0; stb_q <= 1'b0; ovld_q <= 1'b0;
    end else begin
      ph_q <= ph_d; stb_q <= fire; ovld_q <= stb_q;
    end
  end

  assign lane_in[0] = in_re;
  assign lane_in[1] = in_im;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [RW-1:0] isum, cout;
    cicdd_integ #(.DW(DW), .RW(RW), .NS(NS)) u_int (
      .clk(clk), .rst_n(rst_n), .en(in_vld), .din(lane_in[g]), .sum_nxt(isum));
    cicdd_comb #(.RW(RW), .NS(NS)) u_comb (
      .clk(clk), .rst_n(rst_n), .en(fire), .din(isum), .dout(cout));
    cicdd_eq #(.DW(DW), .RW(RW), .CW(CW), .NSH(RW), .NRM(NRM), .MW(MW)) u_eq (
      .clk(clk), .rst_n(rst_n), .load(fire), .emit(stb_q), .cic_in(cout),
      .ca(coef_a), .cb(coef_b), .dout(lane_out[g]));
  end

  assign out_vld = ovld_q;
  assign out_re  = lane_out[0];
  assign out_im  = lane_out[1];

  // R10: phase counter stays inside its modulus
  a_r10_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q < PHW'(ND));
  // R3: no accepted sample, no phase movement
  a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(ph_q));
  // R2: strobe never repeats on the next cycle
  a_r2_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);
  // R2: every strobe traces back to a sample accepted two edges earlier
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld, 2));
endmodule

// File: tb/cic_droop_decim_test.sv
`timescale 1ns/1ps
module cic_droop_decim_test;
  localparam int DW = 12, K = 3, ND = 5, CW = 16;
  localparam int NS = K + 1;
  localparam int NTAP = NS * (ND - 1) + 1;
  localparam longint M = 26844;
  localparam int F = 24;
  localparam int MAXS = 4096;

  logic clk = 1'b0, rst_n = 1'b0, in_vld = 1'b0;
  logic signed [DW-1:0] in_re = '0, in_im = '0;
  logic signed [CW-1:0] coef_a = -16'sd2048, coef_b = 16'sd20480;
  logic out_vld;
  logic signed [DW-1:0] out_re, out_im;

  cic_droop_decim #(.DW(DW), .K(K), .ND(ND), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_re(in_re), .in_im(in_im),
    .coef_a(coef_a), .coef_b(coef_b), .out_vld(out_vld), .out_re(out_re), .out_im(out_im));

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  longint h [NTAP];
  longint xr [MAXS], xi [MAXS];
  int nacc;
  longint yr [3], yi [3];
  longint q_re [$], q_im [$];
  int q_cyc [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic longint norm(input longint c);
    return (c * M + (longint'(1) << (F-1))) >>> F;
  endfunction

  function automatic longint eqz(input longint y0, input longint y1, input longint y2);
    longint s;
    s = (longint'(coef_a) * y0 + longint'(coef_b) * y1 + longint'(coef_a) * y2 + 8192) >>> 14;
    if (s > 2047) s = 2047;
    if (s < -2048) s = -2048;
    return s;
  endfunction

  task automatic model_accept(input longint re, input longint im);
    longint cr, ci;
    xr[nacc] = re; xi[nacc] = im; nacc++;
    if (nacc % ND == 0) begin
      cr = 0; ci = 0;
      for (int j = 0; j < NTAP; j++)
        if (nacc - 1 - j >= 0) begin
          cr += h[j] * xr[nacc-1-j];
          ci += h[j] * xi[nacc-1-j];
        end
      yr[2] = yr[1]; yr[1] = yr[0]; yr[0] = norm(cr);
      yi[2] = yi[1]; yi[1] = yi[0]; yi[0] = norm(ci);
      q_re.push_back(eqz(yr[0], yr[1], yr[2]));
      q_im.push_back(eqz(yi[0], yi[1], yi[2]));
      q_cyc.push_back(cyc + 2);
    end
  endtask

  // Output monitor, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (q_re.size() == 0) check(0, "R2 unexpected out_vld", 1, 0);
      else begin
        longint er, ei; int ec;
        er = q_re.pop_front(); ei = q_im.pop_front(); ec = q_cyc.pop_front();
        check(out_re == er, "R4/R6 out_re", out_re, er);
        check(out_im == ei, "R8 out_im", out_im, ei);
        check(cyc == ec, "R2 latency", cyc, ec);
      end
    end
  end

  task automatic do_reset;
    @(negedge clk);
    in_vld = 0; rst_n = 0;
    nacc = 0;
    for (int i = 0; i < 3; i++) begin yr[i] = 0; yi[i] = 0; end
    q_re.delete(); q_im.delete(); q_cyc.delete();
    repeat (3) @(negedge clk);
    check(out_vld == 0, "R1 out_vld in reset", out_vld, 0);
    check(out_re == 0 && out_im == 0, "R1 outputs in reset", out_re, 0);
    rst_n = 1;
  endtask

  task automatic push(input int re, input int im);
    @(negedge clk);
    in_vld = 1; in_re = DW'(re); in_im = DW'(im);
    model_accept(re, im);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); in_vld = 0; end
  endtask

  task automatic drain(input string tag);
    idle(6);
    check(q_re.size() == 0, tag, q_re.size(), 0);
  endtask

  task automatic t_reset;
    do_reset();
    idle(4);
    check(out_vld == 0 && out_re == 0, "R1 idle after release", out_vld, 0);
  endtask

  task automatic t_step;
    do_reset();
    for (int i = 0; i < 60; i++) push(1000, -700);
    drain("R2 step outputs all seen");
    check(out_re == 1000, "R5 settled DC real", out_re, 1000);
    check(out_im == -700, "R5 settled DC imag", out_im, -700);
  endtask

  task automatic t_impulse;
    do_reset();
    push(2000, 0);
    for (int i = 0; i < 39; i++) push(0, 0);
    drain("R4 impulse outputs all seen");
  endtask

  task automatic t_ramp;
    do_reset();
    for (int i = 0; i < 80; i++) push(((i * 137) % 4096) - 2048, ((i * 911) % 3000) - 1500);
    drain("R4 ramp outputs all seen");
  endtask

  task automatic t_gaps;
    do_reset();
    for (int i = 0; i < 42; i++) begin
      push((i * 53) % 1500 - 700, 300 - (i * 29) % 600);
      idle(i % 4);
      if (i == 20) idle(15);
    end
    drain("R3/R10 gapped outputs all seen");
  endtask

  task automatic t_sat;
    do_reset();
    coef_a = 16'sd0; coef_b = 16'sd32767;
    for (int i = 0; i < 30; i++) push(2047, -2048);
    drain("R7 clamp outputs all seen");
    check(out_re == 2047, "R7 positive clamp", out_re, 2047);
    check(out_im == -2048, "R7 negative clamp", out_im, -2048);
    coef_a = -16'sd2048; coef_b = 16'sd20480;
  endtask

  task automatic t_coef;
    do_reset();
    for (int i = 0; i < 20; i++) push(i * 40 - 300, 500 - i * 25);
    drain("R9 first pair");
    coef_a = 16'sd4096; coef_b = 16'sd8192;
    for (int i = 0; i < 20; i++) push(600 - i * 30, i * 35 - 200);
    drain("R9 changed pair used");
    coef_a = -16'sd2048; coef_b = 16'sd20480;
  endtask

  task automatic t_lane_iso;
    do_reset();
    for (int i = 0; i < 30; i++) push(1800 - i * 90, 0);
    drain("R8 zero lane outputs all seen");
    check(out_im == 0, "R8 idle imaginary lane", out_im, 0);
  endtask

  initial begin
    longint tmp [NTAP];
    int len;
    for (int i = 0; i < NTAP; i++) h[i] = 0;
    h[0] = 1; len = 1;
    for (int s = 0; s < NS; s++) begin
      for (int i = 0; i < NTAP; i++) begin
        tmp[i] = 0;
        for (int j = 0; j < ND; j++) if (i - j >= 0 && i - j < len) tmp[i] += h[i-j];
      end
      len = len + ND - 1;
      for (int i = 0; i < NTAP; i++) h[i] = tmp[i];
    end
    t_reset();
    t_step();
    t_impulse();
    t_ramp();
    t_gaps();
    t_sat();
    t_coef();
    t_lane_iso();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule